// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Code Register

This block is the parallel-loading front end of a 14-bit converter. A host writes a two's complement code into a staging (input) register over a parallel bus, framed by an active-low select and an active-low write strobe. An active-low load strobe then copies the staged code into the output register. Only the output register drives the code that feeds the converter model.

All three strobes are sampled on the system clock through two-flop synchronizers. The level-sensitive behaviour of a pair of transparent latches is rebuilt from the synchronized levels. The staging register follows the bus while a write is active and freezes when the write ends. The output register follows the staging register while load is low.

The two registers are interlocked, so they never pass data at the same time. While a write is active, the output register is blocked even when load is low. As a result, load can be tied permanently low: the output then takes each new code cleanly at the moment the write that produced it finishes. The data bus is delayed by the same number of stages as the strobes, so it stays aligned with them.

Top module: `dac_dbuf_latch`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears both the staging register and the output register to zero, which is the mid-scale code of the two's complement range.
- R2: A write is active while sel_n and wr_n are both low. While a write is active, the staging register follows bus_in on every clock.
- R3: Once sel_n or wr_n returns high, the staging register keeps the last code it took. Later changes on bus_in have no effect on it.
- R4: While ld_n is low and no write is active, the output register copies the staging register. The output therefore updates when ld_n falls.
- R5: While ld_n is high, code_out does not change.
- R6: While a write is active, code_out does not change, even when ld_n is low.
- R7: With ld_n held low, code_out takes the newly staged code as soon as sel_n or wr_n returns high.
- R8: Each strobe and the bus pass through two synchronizing stages. A fall of ld_n with the staging register settled leaves code_out unchanged after two rising edges and updated after the third.
- R9: All 14 bits pass unchanged, with bit 13 as the MSB and bit 0 as the LSB. The extreme codes 0x1FFF (+8191) and 0x2000 (-8192) are carried intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load strobe into the output register, active low |
| bus_in | input | 14 | Parallel two's complement code, bit 13 MSB |
| code_out | output | 14 | Output register contents feeding the converter |

## Verification
The assertions observe the synchronized strobe levels and the aligned bus. They assume that the raw strobes and the bus stay steady long enough for both synchronizing stages to pass a level, so that every write window lasts at least one clock after synchronization. The stimulus keeps to this assumption by driving each input only on the falling clock edge. It also holds most settings for six clocks and changes the bus only together with, or while, the strobes are in a stable state.

// File: rtl/dac_dbuf_latch.sv
module dac_dbuf_latch #(
  parameter int WIDTH       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] code_out
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sel_q, wr_q, ld_q;
  logic [WIDTH-1:0]       bus_q [SYNC_STAGES];
  logic [WIDTH-1:0]       in_reg, dac_reg;
  logic                   wr_active, dac_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '1;
      wr_q  <= '1;
      ld_q  <= '1;
    end else begin
      sel_q <= {sel_q[LAST-1:0], sel_n};
      wr_q  <= {wr_q[LAST-1:0],  wr_n};
      ld_q  <= {ld_q[LAST-1:0],  ld_n};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) bus_q[i] <= '0;
    end else begin
      bus_q[0] <= bus_in;
      for (int i = 1; i < SYNC_STAGES; i++) bus_q[i] <= bus_q[i-1];
    end
  end

  assign wr_active = !sel_q[LAST] && !wr_q[LAST];
  assign dac_open  = !ld_q[LAST] && !wr_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_reg  <= '0;
      dac_reg <= '0;
    end else begin
      if (wr_active) in_reg  <= bus_q[LAST];
      if (dac_open)  dac_reg <= in_reg;
    end
  end

  assign code_out = dac_reg;

endmodule

module dac_dbuf_latch_chk #(
  parameter int WIDTH = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_active,
  input logic             ld_sync_n,
  input logic             dac_open,
  input logic [WIDTH-1:0] bus_al,
  input logic [WIDTH-1:0] in_reg,
  input logic [WIDTH-1:0] code_out
);

  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (code_out == '0 && in_reg == '0));

  a_r2_follow_bus: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active |=> in_reg == $past(bus_al));

  a_r3_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_active |=> $stable(in_reg));

  a_r4_copy_stage: assert property (@(posedge clk) disable iff (!rst_n)
    dac_open |=> code_out == $past(in_reg));

  a_r5_load_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sync_n |=> $stable(code_out));

  a_r6_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active |=> $stable(code_out));

endmodule

bind dac_dbuf_latch dac_dbuf_latch_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_active (wr_active),
  .ld_sync_n (ld_q[LAST]),
  .dac_open  (dac_open),
  .bus_al    (bus_q[LAST]),
  .in_reg    (in_reg),
  .code_out  (code_out)
);

// File: tb/dac_dbuf_latch_tb.sv
module dac_dbuf_latch_tb;

  localparam int W = 14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
  logic [W-1:0] bus_in = '0;
  logic [W-1:0] code_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dac_dbuf_latch u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .ld_n(ld_n),
    .bus_in(bus_in), .code_out(code_out)
  );

  // {sel_n, wr_n, ld_n, bus, expected code_out}
  localparam int NV = 15;
  localparam logic [2+2*W:0] VEC [NV] = '{
    {3'b111, 14'h1234, 14'h0000},  // R5 idle
    {3'b001, 14'h1234, 14'h0000},  // R5 write, load high
    {3'b001, 14'h0ABC, 14'h0000},  // R2 stage follows
    {3'b101, 14'h0ABC, 14'h0000},  // R3 select ends write
    {3'b101, 14'h3FFF, 14'h0000},  // R3 bus ignored
    {3'b100, 14'h3FFF, 14'h0ABC},  // R4 load falls
    {3'b111, 14'h2000, 14'h0ABC},  // R5
    {3'b001, 14'h2000, 14'h0ABC},  // R6 write
    {3'b000, 14'h2000, 14'h0ABC},  // R6 load low blocked
    {3'b000, 14'h1FFF, 14'h0ABC},  // R6
    {3'b010, 14'h1FFF, 14'h1FFF},  // R7 R9 write ends
    {3'b010, 14'h0555, 14'h1FFF},  // R3
    {3'b000, 14'h2000, 14'h1FFF},  // R6
    {3'b100, 14'h2000, 14'h2000},  // R7 R9 select ends
    {3'b111, 14'h0000, 14'h2000}   // R5
  };

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: code_out=%h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(4);
    chk(code_out, 14'h0000, "R1");
    rst_n = 1'b1;
    cyc(2);

    for (int v = 0; v < NV; v++) begin
      {sel_n, wr_n, ld_n} = VEC[v][2+2*W -: 3];
      bus_in = VEC[v][2*W-1 -: W];
      cyc(6);
      chk(code_out, VEC[v][W-1:0], $sformatf("R4/R6 vector %0d", v));
    end

    // R1 mid-run reset clears both registers
    rst_n = 1'b0;
    cyc(2);
    chk(code_out, 14'h0000, "R1");
    rst_n = 1'b1; ld_n = 1'b0;
    cyc(6);
    chk(code_out, 14'h0000, "R1 staging cleared");

    // R8 latency of a load fall
    ld_n = 1'b1; bus_in = 14'h0123; sel_n = 1'b0; wr_n = 1'b0;
    cyc(6);
    wr_n = 1'b1;
    cyc(6);
    chk(code_out, 14'h0000, "R8 before load");
    ld_n = 1'b0;
    cyc(2);
    chk(code_out, 14'h0000, "R8 two edges");
    cyc(1);
    chk(code_out, 14'h0123, "R8 three edges");

    // R6 per-cycle: output steady during a long write with load low
    wr_n = 1'b0;
    for (int k = 0; k < 10; k++) begin
      bus_in = 14'(k * 14'h0311 + 14'h0007);
      cyc(1);
      chk(code_out, 14'h0123, "R6 steady during write");
    end
    wr_n = 1'b1;
    cyc(6);
    chk(code_out, 14'(9 * 14'h0311 + 14'h0007), "R7 last bus value");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule